// File: doc/BRIEF.md
# DPLL Holdover Frequency Generator

This block supplies the frequency word a digital PLL runs at once its reference is gone. It watches the loop filter's integral-path word, which is the slow, bandwidth-limited part of the loop. From it the block keeps two stored values. One is a delayed snapshot that is always between one and two snapshot periods old. The other is a running average over a fixed number of millisecond samples taken while the loop is locked. The proportional path never reaches the block, so recent phase hits cannot leak into the stored value.

The loop controller tells the block when full holdover is active, and the reference monitor raises a fast-isolation flag when the reference drops. On fast isolation the block enters a short mini-holdover at once and stays there until the reference is declared active again or full holdover takes over. Configuration picks one of three sources for the output word: free-run (nominal oscillator word plus a programmable offset), averaged, or instantaneous. A real-time ready bit and a sticky latched copy report when a valid average exists.

Top module: `dpll_holdover_gen`

## Requirements
- R1: After reset, `ho_sel`, `rdy_now` and `rdy_latched` are 0, and in instantaneous mode `ho_freq` is 0.
- R2: Each `ms_tick` that arrives while unfrozen advances a snapshot counter. On every SNAP_MS-th such tick, the older snapshot takes the newer one and the newer one takes `integ_freq`. Cycles without a tick change nothing.
- R3: With `cfg_freerun`=0 and `cfg_avg`=0, `ho_freq` equals the older snapshot, which is the integral word captured SNAP_MS to 2*SNAP_MS ticks earlier.
- R4: While locked and unfrozen, each tick adds `integ_freq` to an accumulator. On the AVG_N-th sample the stored average becomes floor(sum/AVG_N) exactly, the accumulator restarts, and `rdy_now` is 1 from the next cycle.
- R5: With `cfg_freerun`=0 and `cfg_avg`=1, `ho_freq` is the stored average when `rdy_now`=1 and mini-holdover is not active. Otherwise it falls back to the older snapshot.
- R6: With `cfg_freerun`=1, `ho_freq` equals NOM_FREQ + `osc_offset` modulo 2^W (the offset is two's complement). `cfg_avg`, full holdover and mini-holdover do not change this.
- R7: `ho_sel` is 1 while `in_holdover` or `fast_iso` is 1, and also while mini-holdover is latched. Mini-holdover latches on `fast_iso`. It ends on the first clock edge at which `ref_active`=1 or `in_holdover`=1.
- R8: Outside free-run, mini-holdover (without `in_holdover`) drives the older snapshot even when a ready average exists. When `in_holdover`=1 as well, full holdover wins and the averaged-mode rule of R5 applies.
- R9: While `in_holdover`, `fast_iso` or latched mini-holdover is active, the snapshots, the counters, the accumulator, the average and `rdy_now` all keep their values, whatever ticks or lock changes arrive.
- R10: An unfrozen cycle with `locked`=0 clears the accumulator and sample count and drops `rdy_now` on the next edge. Averaging after relock therefore starts from an empty window.
- R11: `rdy_latched` becomes 1 on the edge after `rdy_now` is 1 and then holds. A `rdy_clr` pulse clears it only while `rdy_now` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| integ_freq | input | W | Loop-filter integral-path frequency word |
| locked | input | 1 | Loop is phase-locked |
| ref_active | input | 1 | Selected reference declared active |
| fast_iso | input | 1 | Fast reference-isolation event |
| in_holdover | input | 1 | Full holdover state is active |
| cfg_freerun | input | 1 | 1 selects free-run holdover |
| cfg_avg | input | 1 | 1 selects averaged mode (ignored in free-run) |
| osc_offset | input | W | Two's-complement offset added to the nominal word |
| rdy_clr | input | 1 | Write-one-to-clear strobe for the latched ready bit |
| ho_freq | output | W | Holdover frequency word |
| ho_sel | output | 1 | Loop should use `ho_freq` instead of its integral path |
| rdy_now | output | 1 | Real-time average-ready status |
| rdy_latched | output | 1 | Sticky average-ready status |

## Verification
The hardest state to reach from the ports is a completed average whose value differs from the snapshot, with a known phase of the snapshot counter. Only then can the source-selection rules be told apart. The stimulus first runs a full window of ticks with a varying integral word, interleaved with idle cycles that carry junk data. It then applies a table of mode and flag combinations against that fixed state. Directed sequences follow: they freeze the block through mini-holdover and full holdover while ticks keep arriving, and break lock partway through a window so that a constant-value window after relock must average exactly to that constant.

// File: rtl/dpll_holdover_gen.sv
module dpll_holdover_gen #(
  parameter int W        = 24,
  parameter int SNAP_MS  = 50,
  parameter int AVG_N    = 1000,
  parameter int NOM_FREQ = 32'h0080_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ms_tick,
  input  logic [W-1:0] integ_freq,
  input  logic         locked,
  input  logic         ref_active,
  input  logic         fast_iso,
  input  logic         in_holdover,
  input  logic         cfg_freerun,
  input  logic         cfg_avg,
  input  logic [W-1:0] osc_offset,
  input  logic         rdy_clr,
  output logic [W-1:0] ho_freq,
  output logic         ho_sel,
  output logic         rdy_now,
  output logic         rdy_latched
);
  localparam int SCW = (SNAP_MS > 1) ? $clog2(SNAP_MS) : 1;
  localparam int LGN = $clog2(AVG_N);
  localparam int SW  = W + LGN;
  localparam int RSH = W + 2 * LGN;
  localparam int RW  = RSH - LGN + 2;
  localparam int PW  = SW + RW;
  localparam logic [PW-1:0] RECIP = ((PW'(1) << RSH) + PW'(AVG_N - 1)) / PW'(AVG_N);

  logic [W-1:0]   snap_new, snap_old, avg_q;
  logic [SCW-1:0] ms_cnt;
  logic [LGN-1:0] smp_cnt;
  logic [SW-1:0]  acc;
  logic           avg_ok, lat_q, mini_q;

  wire frozen   = in_holdover | fast_iso | mini_q;
  wire mini_act = ~in_holdover & (fast_iso | mini_q);
  wire win_done = smp_cnt == LGN'(AVG_N - 1);
  wire [SW-1:0] sum_full = acc + SW'(integ_freq);
  wire [PW-1:0] prod     = PW'(sum_full) * RECIP;
  wire [W-1:0]  avg_next = W'(prod >> RSH);
  wire [W-1:0]  fr_word  = W'(NOM_FREQ) + osc_offset;

  always_ff @(posedge clk) begin
    if (!rst_n) mini_q <= 1'b0;
    else        mini_q <= ~in_holdover & (fast_iso | (mini_q & ~ref_active));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms_cnt   <= '0;
      snap_new <= '0;
      snap_old <= '0;
    end else if (ms_tick && !frozen) begin
      if (ms_cnt == SCW'(SNAP_MS - 1)) begin
        ms_cnt   <= '0;
        snap_old <= snap_new;
        snap_new <= integ_freq;
      end else begin
        ms_cnt <= ms_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      smp_cnt <= '0;
      avg_q   <= '0;
      avg_ok  <= 1'b0;
    end else if (!frozen) begin
      if (!locked) begin
        acc     <= '0;
        smp_cnt <= '0;
        avg_ok  <= 1'b0;
      end else if (ms_tick) begin
        if (win_done) begin
          avg_q   <= avg_next;
          avg_ok  <= 1'b1;
          acc     <= '0;
          smp_cnt <= '0;
        end else begin
          acc     <= sum_full;
          smp_cnt <= smp_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= avg_ok | (lat_q & ~rdy_clr);
  end

  assign ho_freq     = cfg_freerun ? fr_word :
                       (cfg_avg && avg_ok && !mini_act) ? avg_q : snap_old;
  assign ho_sel      = in_holdover | fast_iso | mini_q;
  assign rdy_now     = avg_ok;
  assign rdy_latched = lat_q;

  AST_MINI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mini_q && !ref_active && !in_holdover) |=> ho_sel); // R7
  AST_FRZ_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(snap_old) && $stable(snap_new) && $stable(ms_cnt))); // R9
  AST_FRZ_AVG: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(avg_q) && $stable(acc) && $stable(avg_ok))); // R9
  AST_UNLOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !frozen) |=> (!rdy_now && acc == '0)); // R10
  AST_LAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_now |=> rdy_latched); // R11
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_cnt < LGN'(AVG_N)); // R4
endmodule

// File: tb/dpll_holdover_gen_tb.sv
module dpll_holdover_gen_tb;
  localparam int W = 24;
  localparam logic [W-1:0] NOM = 24'h80_0000;
  // {freerun, avg, iso, hold, exp_sel, src[1:0]}; src 0 snapshot, 1 average, 2 free-run
  localparam logic [6:0] VEC [0:10] = '{
    7'b0000_0_00, 7'b0100_0_01, 7'b0001_1_00, 7'b0101_1_01, 7'b0110_1_00,
    7'b0010_1_00, 7'b0111_1_01, 7'b1001_1_10, 7'b1101_1_10, 7'b1110_1_10,
    7'b1000_0_10 };

  logic clk = 0, rst_n = 0;
  logic tick = 0, lk = 0, ref_ok = 1, iso = 0, hold = 0, fr = 0, avm = 0, clr = 0;
  logic [W-1:0] val = '0, off = '0;
  logic [W-1:0] ho_freq;
  logic ho_sel, rdy_now, rdy_latched;
  int total = 0, bad = 0;
  int tcnt = 0, bn = 0;
  longint bsum = 0;
  logic [W-1:0] s_old = '0, s_new = '0, e_avg = '0, sv_snap, sv_avg;
  logic e_rdy = 0, e_lat = 0, mini_m = 0;

  always #5 clk = ~clk;

  dpll_holdover_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(tick), .integ_freq(val), .locked(lk),
    .ref_active(ref_ok), .fast_iso(iso), .in_holdover(hold), .cfg_freerun(fr),
    .cfg_avg(avm), .osc_offset(off), .rdy_clr(clr), .ho_freq(ho_freq),
    .ho_sel(ho_sel), .rdy_now(rdy_now), .rdy_latched(rdy_latched));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_freq();
    if (fr) return NOM + off;
    if (avm && e_rdy && !(!hold && (iso || mini_m))) return e_avg;
    return s_old;
  endfunction

  task automatic step(input logic t, input logic [W-1:0] v);
    logic frz;
    tick = t; val = v;
    @(posedge clk);
    frz = hold | iso | mini_m;
    e_lat = e_rdy | (e_lat & ~clr);
    if (!frz) begin
      if (!lk) begin bsum = 0; bn = 0; e_rdy = 0; end
      else if (t) begin
        bsum += longint'(v); bn++;
        if (bn == 1000) begin e_avg = W'(bsum / 1000); e_rdy = 1; bsum = 0; bn = 0; end
      end
      if (t) begin
        tcnt++;
        if (tcnt % 50 == 0) begin s_old = s_new; s_new = v; end
      end
    end
    mini_m = ~hold & (iso | (mini_m & ~ref_ok));
    @(negedge clk);
    tick = 0;
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " freq"}, 32'(ho_freq), 32'(exp_freq()));
    chk({tag, " sel"}, 32'(ho_sel), 32'(hold | iso | mini_m));
    chk({tag, " rdy"}, 32'(rdy_now), 32'(e_rdy));
    chk({tag, " lat"}, 32'(rdy_latched), 32'(e_lat));
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_all("R1 reset");
    chk("R1 freq zero", 32'(ho_freq), 0);
    lk = 1;
    for (int i = 1; i <= 100; i++) step(1, 24'd100);
    chk("R2 R3 snap after 100", 32'(ho_freq), 100);
    for (int i = 101; i <= 150; i++) begin step(1, 24'd200); step(0, 24'hFFFFFF); end
    chk("R3 snap delayed", 32'(ho_freq), 100);
    for (int i = 151; i <= 200; i++) step(1, 24'd200);
    chk("R2 R3 snap 200", 32'(ho_freq), 200);
    avm = 1;
    for (int i = 201; i <= 999; i++) begin
      step(1, W'(1000 + (i * 37) % 500));
      if (i % 3 == 0) step(0, 24'h00ABCD);
    end
    chk("R5 fallback not ready", 32'(ho_freq), 32'(s_old));
    chk("R4 not ready yet", 32'(rdy_now), 0);
    step(1, 24'd1234);
    chk("R4 ready after window", 32'(rdy_now), 1);
    chk("R4 R5 average", 32'(ho_freq), 32'(e_avg));
    chk("R11 latch lags", 32'(rdy_latched), 0);
    step(0, '0);
    chk("R11 latch set", 32'(rdy_latched), 1);
    chk_all("R4 state");

    off = 24'hFFFFF0;
    ref_ok = 1;
    foreach (VEC[k]) begin
      logic [W-1:0] ev;
      {fr, avm, iso, hold} = VEC[k][6:3];
      #1;
      ev = (VEC[k][1:0] == 2'd2) ? 24'h7FFFF0 : (VEC[k][1:0] == 2'd1) ? e_avg : s_old;
      chk($sformatf("R6 R8 row%0d freq", k), 32'(ho_freq), 32'(ev));
      chk($sformatf("R7 row%0d sel", k), 32'(ho_sel), 32'(VEC[k][2]));
      iso = 0; hold = 0;
      step(0, '0);
    end
    fr = 0; avm = 1;

    sv_snap = s_old; sv_avg = e_avg;
    ref_ok = 0; iso = 1;
    step(1, 24'd777);
    iso = 0;
    for (int i = 0; i < 60; i++) step(1, 24'd999);
    chk("R7 mini persists", 32'(ho_sel), 1);
    chk("R8 mini uses snapshot", 32'(ho_freq), 32'(sv_snap));
    chk("R9 mini freeze rdy", 32'(rdy_now), 1);
    chk_all("R9 mini");
    ref_ok = 1;
    #1 chk("R7 sel until edge", 32'(ho_sel), 1);
    step(0, '0);
    chk("R7 ref ends mini", 32'(ho_sel), 0);
    chk("R9 avg kept", 32'(ho_freq), 32'(sv_avg));
    ref_ok = 0; iso = 1;
    step(0, '0);
    iso = 0; hold = 1;
    step(0, '0);
    hold = 0;
    step(0, '0);
    chk("R7 holdover ends mini", 32'(ho_sel), 0);

    hold = 1;
    for (int i = 0; i < 120; i++) step(1, 24'd5);
    lk = 0;
    step(1, 24'd5);
    avm = 0; #1 chk("R9 hold snap", 32'(ho_freq), 32'(sv_snap));
    avm = 1; #1 chk("R9 hold avg", 32'(ho_freq), 32'(sv_avg));
    chk("R9 hold rdy", 32'(rdy_now), 1);
    chk_all("R9 hold");
    hold = 0; ref_ok = 1;

    step(0, '0);
    chk("R10 rdy drops", 32'(rdy_now), 0);
    chk("R5 R10 fallback", 32'(ho_freq), 32'(s_old));
    step(0, '0);
    chk("R11 latch holds", 32'(rdy_latched), 1);
    clr = 1; step(0, '0); clr = 0;
    chk("R11 clear", 32'(rdy_latched), 0);
    lk = 1;
    for (int i = 0; i < 300; i++) step(1, 24'd50000);
    lk = 0; step(0, '0); lk = 1;
    for (int i = 0; i < 1000; i++) step(1, 24'd12345);
    chk("R10 clean window", 32'(ho_freq), 12345);
    chk("R4 rdy again", 32'(rdy_now), 1);
    step(0, '0);
    clr = 1; step(0, '0); clr = 0;
    chk("R11 clear ignored when ready", 32'(rdy_latched), 1);
    fr = 1; avm = 0; off = 24'h000100;
    #1 chk("R6 freerun positive offset", 32'(ho_freq), 32'h800100);
    chk_all("R6 final");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule